// File: doc/BRIEF.md
# Return Address Stack with Coroutine Swap Handling

This block predicts return targets for a RISC-V fetch frontend. Each cycle it may receive one fetched instruction, either a 32-bit word or a compressed 16-bit one, along with its PC. It sorts the instruction into one of four classes: call, pure return, coroutine swap or none. It then updates a small circular stack of return addresses. A call pushes the address of the next sequential instruction. A pure return pops, and the entry it pops is the predicted target. A coroutine swap is a jump-and-link-register whose source and destination are two different link registers. It pops and then pushes in the same cycle. Its target is not predicted from the stack, because it is resolved on the same indirect path as an ordinary call.

The class flags are brought out so that downstream prediction checking can use them. Only the pure-return flag qualifies a slot as a forced taken return. To recover after a redirect, the frontend takes a snapshot of the top pointer and the top entry. Later it can reload both in a single cycle. A restore takes priority over any stack operation in the same cycle.

Top module: `ret_addr_stack`

## Requirements
- R1: A 32-bit jal (opcode 1101111) or a 32-bit jalr (opcode 1100111, funct3 000) is a call when its destination (bits 11:7) is x1 or x5. A compressed jal (bits 1:0 = 01, bits 15:13 = 001) is never a call and never a return.
- R2: A compressed jr/jalr is recognised when bits 1:0 = 10, bits 15:13 = 100, bits 6:2 = 0 and source bits 11:7 are nonzero. Bit 12 set means the destination is x1, and bit 12 clear means the destination is x0.
- R3: A jalr whose source (bits 19:15 for 32-bit) is x1 or x5 and whose destination is not a link register raises `isRet`, `isPureRet` and `predValid` together. `predTarget` shows the top entry, and the stack pops.
- R4: A jalr whose source and destination are x1 and x5 in either order raises both `isCall` and `isRet`, keeps `isPureRet` and `predValid` low, and replaces the top entry with the return address. The depth is unchanged.
- R5: A jalr whose source and destination are the same link register is a call only. It pushes and does not pop.
- R6: The pushed return address is PC+4 for a 32-bit instruction and PC+2 for a compressed one. It appears on `predTarget` in the cycle after the push.
- R7: The stack is circular with `DEPTH` entries. A push beyond `DEPTH` overwrites the oldest entry.
- R8: A pop on an exhausted stack still presents the current top entry and still moves the pointer.
- R9: `snapTake` records the top pointer and top entry. `snapRestore` reloads both on the next edge. A call or return in the same cycle as a restore has no effect on the stack.
- R10: While `instValid` is low, or for a non-control-flow instruction, all class flags and `predValid` are low and the stack is unchanged.
- R11: Synchronous active-high reset empties the stack, so `predTarget` reads zero and the snapshot reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instValid | input | 1 | Fetched instruction present |
| instWord | input | 32 | Instruction bits (compressed in bits 15:0) |
| instPc | input | ADDR_W | PC of the instruction |
| snapTake | input | 1 | Record top pointer and top entry |
| snapRestore | input | 1 | Reload recorded pointer and entry |
| predTarget | output | ADDR_W | Current top-of-stack address |
| predValid | output | 1 | Target is a valid return prediction |
| isCall | output | 1 | Instruction links (pushes) |
| isRet | output | 1 | Instruction returns (pops) |
| isPureRet | output | 1 | Return that is not also a call |

## Verification
The bench builds the block with `DEPTH` = 4 and `ADDR_W` = 16. With a four-entry stack, wraparound on overflow and on underflow takes only a handful of pushes or pops, so both can be checked many times within a short run. The small depth also leaves room to sweep every source/destination register pair of the 32-bit jalr and every compressed jr/jalr source with both link settings, while a stack model in the bench tracks the contents. Snapshot and restore are checked together with a call or return in the same cycle, to confirm that the restore takes priority.

// File: rtl/ras_pkg.sv
package ras_pkg;

  typedef enum logic [1:0] {
    CLS_NONE     = 2'd0,
    CLS_CALL     = 2'd1,
    CLS_PURE_RET = 2'd2,
    CLS_SWAP     = 2'd3
  } rasClass_e;

  typedef struct packed {
    logic push;
    logic pop;
    logic swap;
    logic restore;
    logic snap;
  } rasStrobe_t;

  function automatic logic isLinkReg(input logic [4:0] r);
    return (r == 5'd1) || (r == 5'd5);
  endfunction

endpackage

// File: rtl/ras_decode.sv
module ras_decode #(
  parameter int ADDR_W = 32
) (
  input  logic              instValid,
  input  logic [31:0]       instWord,
  input  logic [ADDR_W-1:0] instPc,
  output logic              callFlag,
  output logic              retFlag,
  output logic [ADDR_W-1:0] retAddr
);
  import ras_pkg::*;

  logic isComp;
  logic jal32;
  logic jalr32;
  logic cJal;
  logic cJr;
  logic jalrAny;
  logic [4:0] rdIdx;
  logic [4:0] rsIdx;
  logic rawCall;

  always_comb begin
    isComp  = (instWord[1:0] != 2'b11);
    jal32   = !isComp && (instWord[6:0] == 7'b1101111);
    jalr32  = !isComp && (instWord[6:0] == 7'b1100111) && (instWord[14:12] == 3'b000);
    cJal    = isComp && (instWord[1:0] == 2'b01) && (instWord[15:13] == 3'b001);
    cJr     = isComp && (instWord[1:0] == 2'b10) && (instWord[15:13] == 3'b100)
              && (instWord[6:2] == 5'd0) && (instWord[11:7] != 5'd0);
    jalrAny = jalr32 || cJr;
    rdIdx   = isComp ? {4'd0, instWord[12]} : instWord[11:7];
    rsIdx   = isComp ? (cJal ? 5'd0 : instWord[11:7]) : instWord[19:15];
    rawCall = (jal32 || jalrAny) && isLinkReg(rdIdx);
    callFlag = instValid && rawCall;
    retFlag  = instValid && jalrAny && isLinkReg(rsIdx)
               && (!rawCall || (rsIdx != rdIdx));
    retAddr  = instPc + (isComp ? ADDR_W'(2) : ADDR_W'(4));
  end

endmodule

// File: rtl/ras_ctrl.sv
module ras_ctrl (
  input  logic                callFlag,
  input  logic                retFlag,
  input  logic                snapTake,
  input  logic                snapRestore,
  output ras_pkg::rasStrobe_t strobe,
  output logic                pureRet
);
  import ras_pkg::*;

  rasClass_e cls;

  always_comb begin
    unique case ({callFlag, retFlag})
      2'b10:   cls = CLS_CALL;
      2'b01:   cls = CLS_PURE_RET;
      2'b11:   cls = CLS_SWAP;
      default: cls = CLS_NONE;
    endcase

    pureRet        = (cls == CLS_PURE_RET);
    strobe.snap    = snapTake;
    strobe.restore = snapRestore;
    strobe.push    = !snapRestore && (cls == CLS_CALL);
    strobe.pop     = !snapRestore && (cls == CLS_PURE_RET);
    strobe.swap    = !snapRestore && (cls == CLS_SWAP);
  end

endmodule

// File: rtl/ras_data.sv
module ras_data #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  ras_pkg::rasStrobe_t strobe,
  input  logic [ADDR_W-1:0]   pushAddr,
  output logic [ADDR_W-1:0]   topEntry
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [ADDR_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  topPtr;
  logic [PTR_W-1:0]  ptrInc;
  logic [PTR_W-1:0]  ptrDec;
  logic [PTR_W-1:0]  savedPtr;
  logic [ADDR_W-1:0] savedTop;
  logic [PTR_W-1:0]  wrIdx;
  logic [ADDR_W-1:0] wrData;
  logic              wrEn;

  always_comb begin
    ptrInc = topPtr + PTR_W'(1);
    ptrDec = topPtr - PTR_W'(1);
    wrEn   = strobe.restore || strobe.push || strobe.swap;
    wrIdx  = strobe.restore ? savedPtr : (strobe.push ? ptrInc : topPtr);
    wrData = strobe.restore ? savedTop : pushAddr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      topPtr <= '0;
    end else if (strobe.restore) begin
      topPtr <= savedPtr;
    end else if (strobe.push) begin
      topPtr <= ptrInc;
    end else if (strobe.pop) begin
      topPtr <= ptrDec;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      savedPtr <= '0;
      savedTop <= '0;
    end else if (strobe.snap) begin
      savedPtr <= topPtr;
      savedTop <= mem[topPtr];
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst) begin
        mem[i] <= '0;
      end else if (wrEn && (wrIdx == PTR_W'(i))) begin
        mem[i] <= wrData;
      end
    end
  end

  assign topEntry = mem[topPtr];

endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instValid,
  input  logic [31:0]       instWord,
  input  logic [ADDR_W-1:0] instPc,
  input  logic              snapTake,
  input  logic              snapRestore,
  output logic [ADDR_W-1:0] predTarget,
  output logic              predValid,
  output logic              isCall,
  output logic              isRet,
  output logic              isPureRet
);
  import ras_pkg::*;

  logic              callFlag;
  logic              retFlag;
  logic              pureRet;
  logic [ADDR_W-1:0] retAddr;
  rasStrobe_t        strobe;

  ras_decode #(.ADDR_W(ADDR_W)) u_decode (
    .instValid (instValid),
    .instWord  (instWord),
    .instPc    (instPc),
    .callFlag  (callFlag),
    .retFlag   (retFlag),
    .retAddr   (retAddr)
  );

  ras_ctrl u_ctrl (
    .callFlag    (callFlag),
    .retFlag     (retFlag),
    .snapTake    (snapTake),
    .snapRestore (snapRestore),
    .strobe      (strobe),
    .pureRet     (pureRet)
  );

  ras_data #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_data (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .pushAddr (retAddr),
    .topEntry (predTarget)
  );

  assign isCall    = callFlag;
  assign isRet     = retFlag;
  assign isPureRet = pureRet;
  assign predValid = pureRet;

endmodule

// File: rtl/ras_checker.sv
module ras_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              instValid,
  input logic [31:0]       instWord,
  input logic [ADDR_W-1:0] instPc,
  input logic              snapRestore,
  input logic [ADDR_W-1:0] predTarget,
  input logic              predValid,
  input logic              isCall,
  input logic              isRet,
  input logic              isPureRet
);
  logic [ADDR_W-1:0] linkExp;
  logic              rstQ = 1'b0;

  assign linkExp = instPc + ((instWord[1:0] == 2'b11) ? ADDR_W'(4) : ADDR_W'(2));

  always_ff @(posedge clk) rstQ <= rst;

  // R11: state right after reset reads empty
  always_ff @(posedge clk) begin
    if (rstQ) begin
      assert_reset_empty_R11: assert (predTarget == '0)
        else $error("top not zero after reset");
    end
  end

  assert_pred_pure_R3: assert property (@(posedge clk) disable iff (rst)
    predValid |-> (isRet && !isCall && isPureRet));

  assert_swap_no_pred_R4: assert property (@(posedge clk) disable iff (rst)
    (isCall && isRet) |-> (!predValid && !isPureRet));

  assert_push_target_R6: assert property (@(posedge clk) disable iff (rst)
    (instValid && isCall && !snapRestore) |=> (predTarget == $past(linkExp)));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !instValid |-> (!isCall && !isRet && !isPureRet && !predValid));

  assert_cjal_no_link_R1: assert property (@(posedge clk) disable iff (rst)
    (instWord[1:0] == 2'b01 && instWord[15:13] == 3'b001) |-> (!isCall && !isRet));

endmodule

bind ret_addr_stack ras_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .instValid   (instValid),
  .instWord    (instWord),
  .instPc      (instPc),
  .snapRestore (snapRestore),
  .predTarget  (predTarget),
  .predValid   (predValid),
  .isCall      (isCall),
  .isRet       (isRet),
  .isPureRet   (isPureRet)
);

// File: tb/ret_addr_stack_tb.sv
`timescale 1ns/1ps
module ret_addr_stack_tb;
  localparam int AW = 16;
  localparam int DP = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          instValid = 1'b0;
  logic [31:0]   instWord = '0;
  logic [AW-1:0] instPc = '0;
  logic          snapTake = 1'b0;
  logic          snapRestore = 1'b0;
  logic [AW-1:0] predTarget;
  logic          predValid, isCall, isRet, isPureRet;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  logic [AW-1:0] mdl [DP];
  int            mPtr = 0;
  int            sPtr = 0;
  logic [AW-1:0] sTop = '0;

  always #5 clk = ~clk;

  ret_addr_stack #(.ADDR_W(AW), .DEPTH(DP)) u_dut (
    .clk(clk), .rst(rst), .instValid(instValid), .instWord(instWord),
    .instPc(instPc), .snapTake(snapTake), .snapRestore(snapRestore),
    .predTarget(predTarget), .predValid(predValid), .isCall(isCall),
    .isRet(isRet), .isPureRet(isPureRet)
  );

  function automatic bit lnk(input int r);
    return (r == 1) || (r == 5);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected class from the requirement encodings
  task automatic expClass(input logic [31:0] w, output bit eCall, output bit eRet, output bit comp);
    bit j32, jr32, cj, cjr;
    int rd, rs;
    comp = (w[1:0] != 2'b11);
    j32  = !comp && w[6:0] == 7'b1101111;
    jr32 = !comp && w[6:0] == 7'b1100111 && w[14:12] == 3'b000;
    cj   = comp && w[1:0] == 2'b01 && w[15:13] == 3'b001;
    cjr  = comp && w[1:0] == 2'b10 && w[15:13] == 3'b100 && w[6:2] == 0 && w[11:7] != 0;
    rd   = comp ? int'(w[12]) : int'(w[11:7]);
    rs   = comp ? (cj ? 0 : int'(w[11:7])) : int'(w[19:15]);
    eCall = (j32 || jr32 || cjr) && lnk(rd);
    eRet  = (jr32 || cjr) && lnk(rs) && (!eCall || rs != rd);
  endtask

  task automatic step(input bit v, input logic [31:0] w, input logic [AW-1:0] pc,
                      input bit sn, input bit rs, input string req);
    bit eCall, eRet, comp, ePure;
    int oldPtr;
    logic [AW-1:0] oldTop;
    @(negedge clk);
    instValid = v; instWord = w; instPc = pc; snapTake = sn; snapRestore = rs;
    #1;
    expClass(w, eCall, eRet, comp);
    eCall = eCall && v;
    eRet  = eRet && v;
    ePure = eRet && !eCall;
    chk(isCall == eCall, req, isCall, eCall);
    chk(isRet == eRet, req, isRet, eRet);
    chk(isPureRet == ePure, req, isPureRet, ePure);
    chk(predValid == ePure, req, predValid, ePure);
    chk(predTarget == mdl[mPtr], req, predTarget, mdl[mPtr]);
    @(posedge clk);
    oldPtr = mPtr;
    oldTop = mdl[mPtr];
    if (rs) begin
      mPtr = sPtr;
      mdl[sPtr] = sTop;
    end else if (eCall && !eRet) begin
      mPtr = (mPtr + 1) % DP;
      mdl[mPtr] = pc + (comp ? AW'(2) : AW'(4));
    end else if (ePure) begin
      mPtr = (mPtr + DP - 1) % DP;
    end else if (eCall && eRet) begin
      mdl[mPtr] = pc + (comp ? AW'(2) : AW'(4));
    end
    if (sn) begin
      sPtr = oldPtr;
      sTop = oldTop;
    end
    #1;
    chk(predTarget == mdl[mPtr], req, predTarget, mdl[mPtr]);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; instValid = 1'b0; snapTake = 1'b0; snapRestore = 1'b0;
    repeat (2) @(posedge clk);
    for (int i = 0; i < DP; i++) mdl[i] = '0;
    mPtr = 0; sPtr = 0; sTop = '0;
    @(negedge clk);
    chk(predTarget == '0, "R11", predTarget, 0);
    chk(predValid == 1'b0, "R11", predValid, 0);
    rst = 1'b0;
  endtask

  function automatic logic [31:0] jalrW(input int rs, input int rd);
    return {12'h010, 5'(rs), 3'b000, 5'(rd), 7'b1100111};
  endfunction

  function automatic logic [31:0] cjrW(input int rs, input bit link);
    return {16'h0000, 3'b100, link, 5'(rs), 5'd0, 2'b10};
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DP; i++) mdl[i] = '0;
    doReset();

    // R1 R3 R4 R5: every register pair of a 32-bit jalr
    for (int rs = 0; rs < 32; rs++) begin
      for (int rd = 0; rd < 32; rd++) begin
        string tag;
        if (lnk(rs) && lnk(rd) && rs != rd) tag = "R4";
        else if (lnk(rs) && lnk(rd)) tag = "R5";
        else if (lnk(rs)) tag = "R3";
        else tag = "R1";
        step(1'b1, jalrW(rs, rd), AW'(16'h1000 + (rs * 32 + rd) * 4), 1'b0, 1'b0, tag);
      end
    end

    // R1 R6: 32-bit jal for every destination
    for (int rd = 0; rd < 32; rd++)
      step(1'b1, {20'h00400, 5'(rd), 7'b1101111}, AW'(16'h4000 + rd * 8), 1'b0, 1'b0, "R6");

    // R2: compressed jr/jalr, every source, both link settings
    for (int lk = 0; lk < 2; lk++)
      for (int rs = 0; rs < 32; rs++)
        step(1'b1, cjrW(rs, lk[0]), AW'(16'h6002 + rs * 6 + lk * 2), 1'b0, 1'b0, "R2");

    // R1: compressed jal never links
    for (int k = 0; k < 4; k++)
      step(1'b1, {16'h0000, 3'b001, 11'(k * 97 + 5), 2'b01}, AW'(16'h7000 + k * 2), 1'b0, 1'b0, "R1");

    // R10: idle or non-control-flow instruction leaves stack intact
    step(1'b1, jalrW(0, 1), 16'h2000, 1'b0, 1'b0, "R6");
    step(1'b0, jalrW(0, 1), 16'h2100, 1'b0, 1'b0, "R10");
    step(1'b0, jalrW(1, 0), 16'h2200, 1'b0, 1'b0, "R10");
    step(1'b1, 32'h00000013, 16'h2300, 1'b0, 1'b0, "R10");
    step(1'b1, 32'h00000001, 16'h2400, 1'b0, 1'b0, "R10");
    step(1'b1, jalrW(5, 0), 16'h2500, 1'b0, 1'b0, "R3");

    // R7: overflow wraps and overwrites oldest, then pop all the way back
    for (int k = 0; k < DP + 3; k++)
      step(1'b1, jalrW(0, 1), AW'(16'h3000 + k * 16), 1'b0, 1'b0, "R7");
    for (int k = 0; k < DP + 3; k++)
      step(1'b1, jalrW(1, 0), 16'h3800, 1'b0, 1'b0, "R7");

    // R8: underflow from empty
    doReset();
    step(1'b1, jalrW(5, 0), 16'h5000, 1'b0, 1'b0, "R8");
    step(1'b1, jalrW(1, 0), 16'h5004, 1'b0, 1'b0, "R8");
    step(1'b1, cjrW(0, 1'b1) | 32'h00000080, 16'h5008, 1'b0, 1'b0, "R8");

    // R9: snapshot, disturb, restore with concurrent call/return
    doReset();
    step(1'b1, jalrW(0, 1), 16'h0a00, 1'b0, 1'b0, "R9");
    step(1'b1, jalrW(0, 5), 16'h0b00, 1'b1, 1'b0, "R9");
    step(1'b1, jalrW(1, 0), 16'h0c00, 1'b0, 1'b0, "R9");
    step(1'b1, jalrW(0, 1), 16'h0d00, 1'b0, 1'b0, "R9");
    step(1'b1, jalrW(5, 1), 16'h0d80, 1'b0, 1'b0, "R4");
    step(1'b1, jalrW(0, 1), 16'h0e00, 1'b0, 1'b1, "R9");
    step(1'b1, jalrW(1, 0), 16'h0f00, 1'b1, 1'b1, "R9");
    step(1'b1, jalrW(1, 0), 16'h0f10, 1'b0, 1'b0, "R9");
    step(1'b1, jalrW(1, 0), 16'h0f20, 1'b0, 1'b0, "R9");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule